// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block connects a synchronous host port to an asynchronous static RAM of 256K words by 16 bits. The host puts up a word address, write data, a per-byte lane mask and a read/write flag. It holds a request until the controller accepts it. The controller then drives the memory's active-low strobes (chip select, write strobe, output enable and one enable per byte lane) through a fixed sequence of phases. Every phase length is worked out when the block is elaborated, as whole clock cycles from nanosecond timing parameters and the clock period. Each access ends with a single-cycle completion pulse, and read data is held in a register.

The memory data bus is split into an output word, an input word and a drive enable, so the tristate buffer sits outside this block. A write runs in two parts. In the first, the write strobe is low and the bus is driven. In the second, the strobe is high, chip select is still low and the bus is released. A write that follows a read first waits out the memory's output release time. After reset the controller stays quiet for the power-up hold-off, and only then does it accept requests.

Top module: `sram_bridge`

## Requirements
- R1: While reset is high, and in the cycle after it is released, mem_cs_n, mem_we_n and mem_oe_n are 1, both bits of mem_be_n are 1, mem_dq_oe is 0, and host_ready and host_done are 0.
- R2: Let P = ceil(T_PWRUP_NS / CLK_NS). host_ready first reads 1 after the (P+1)th rising clock edge following reset release. Until then chip select stays high.
- R3: A read (host_wr = 0) holds mem_cs_n = 0, mem_oe_n = 0 and mem_we_n = 1 for max(ceil(T_RC_NS/CLK_NS), ceil(T_DOE_NS/CLK_NS)) cycles, with a minimum of one. The accepted address is held on mem_addr throughout.
- R4: Read data is registered at the end of the read phase and shows on host_rdata from the completion cycle. It holds until the next read. Lanes whose mask bit is 0 read as zero.
- R5: A write (host_wr = 1) drives mem_cs_n = 0, mem_we_n = 0, mem_oe_n = 1 and mem_dq_oe = 1, with the data held, for max(ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS)) cycles. It then keeps mem_cs_n = 0 with mem_we_n = 1 and the bus released for max(1, ceil(T_WC_NS/CLK_NS) minus the strobe cycles) cycles.
- R6: mem_dq_oe is 1 only while mem_we_n is 0 and mem_oe_n is 1.
- R7: When a write follows a read, the controller first spends ceil(T_HZ_NS/CLK_NS) cycles with all strobes high and the bus released.
- R8: host_done is a one-cycle pulse in the cycle after each access's last phase. During that pulse chip select is high.
- R9: host_ready is 1 only while idle. A request is accepted on a clock edge where both host_req and host_ready are 1. host_ready is 1 again in the cycle after host_done.
- R10: Byte lane i is enabled (mem_be_n[i] = 0) during an access exactly when host_mask[i] was 1. Bit 0 is the low byte (data bits 7:0) and bit 1 is the high byte. With a zero mask the access keeps its full timing but enables no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request valid |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane mask, 1 = lane used |
| host_ready | output | 1 | Controller idle, request can be taken |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Registered read data |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data to memory |
| mem_dq_in | input | 16 | Data from memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
A wrong phase state or phase counter shows on the strobe pins within one cycle, as a strobe edge that is early or late. The bench compares every pin on every cycle of every access, so such an error is reported in the cycle where it occurs. A lost turnaround flag shows as a write strobe falling straight after a read completion. A wrong lane mask or a wrong capture edge shows at the next read-back, because the bench's memory model only stores what the strobes actually wrote. An error in the boot counter moves the first rise of host_ready away from its expected cycle.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_TURN,
    ST_WRITE,
    ST_WREC,
    ST_READ,
    ST_DONE
  } sb_state_e;

  // whole cycles covering a time, never less than one
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sb_phase_timer.sv
module sb_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - CW'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sb_boot_hold.sv
module sb_boot_hold #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst,
  output logic ok
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ok  <= 1'b0;
    end else if (!ok) begin
      if (cnt == CW'(CYC - 1)) ok <= 1'b1;
      else                     cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sb_lane_capture.sv
module sb_lane_capture #(
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic [LANES-1:0]    lane_en,
  input  logic [LANES*LW-1:0] din,
  output logic [LANES*LW-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (capture) q <= lane_en[g] ? din[g*LW +: LW] : '0;
    end
    assign dout[g*LW +: LW] = q;
  end
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int AW         = 18,
  parameter int DW         = 16,
  parameter int CLK_NS     = 20,
  parameter int T_RC_NS    = 45,
  parameter int T_DOE_NS   = 25,
  parameter int T_WC_NS    = 45,
  parameter int T_PWE_NS   = 35,
  parameter int T_SD_NS    = 25,
  parameter int T_HZ_NS    = 15,
  parameter int T_PWRUP_NS = 200000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_wr,
  input  logic [AW-1:0]      host_addr,
  input  logic [DW-1:0]      host_wdata,
  input  logic [DW/8-1:0]    host_mask,
  output logic               host_ready,
  output logic               host_done,
  output logic [DW-1:0]      host_rdata,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_cs_n,
  output logic               mem_we_n,
  output logic               mem_oe_n,
  output logic [DW/8-1:0]    mem_be_n,
  output logic [DW-1:0]      mem_dq_out,
  input  logic [DW-1:0]      mem_dq_in,
  output logic               mem_dq_oe
);
  localparam int LANES   = DW / 8;
  localparam int RD_CYC  = max2(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int WR_CYC  = max2(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS));
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int REC_CYC = (WC_CYC > WR_CYC) ? (WC_CYC - WR_CYC) : 1;
  localparam int TA_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int PWR_CYC = ns_to_cyc(T_PWRUP_NS, CLK_NS);
  localparam int TCW     = $clog2(RD_CYC + WR_CYC + REC_CYC + TA_CYC + 1);

  sb_state_e        state, nxt;
  logic             boot_ok;
  logic             tim_load, tim_last;
  logic [TCW-1:0]   tim_len;
  logic             accept, after_rd, capture;
  logic [LANES-1:0] mask_q, mask_sel;

  sb_boot_hold #(.CYC(PWR_CYC)) i_boot (
    .clk(clk), .rst(rst), .ok(boot_ok)
  );

  sb_phase_timer #(.CW(TCW)) i_timer (
    .clk(clk), .rst(rst), .load(tim_load), .len(tim_len), .last(tim_last)
  );

  sb_lane_capture #(.LANES(LANES), .LW(8)) i_rcap (
    .clk(clk), .rst(rst), .capture(capture), .lane_en(mask_q),
    .din(mem_dq_in), .dout(host_rdata)
  );

  assign accept   = (state == ST_IDLE) && host_req && host_ready;
  assign capture  = (state == ST_READ) && tim_last;
  assign mask_sel = accept ? host_mask : mask_q;

  always_comb begin
    nxt      = state;
    tim_load = 1'b0;
    tim_len  = '0;
    unique case (state)
      ST_BOOT: if (boot_ok) nxt = ST_IDLE;
      ST_IDLE: begin
        if (accept) begin
          tim_load = 1'b1;
          if (!host_wr) begin
            nxt     = ST_READ;
            tim_len = TCW'(RD_CYC);
          end else if (after_rd) begin
            nxt     = ST_TURN;
            tim_len = TCW'(TA_CYC);
          end else begin
            nxt     = ST_WRITE;
            tim_len = TCW'(WR_CYC);
          end
        end
      end
      ST_TURN: if (tim_last) begin
        nxt      = ST_WRITE;
        tim_load = 1'b1;
        tim_len  = TCW'(WR_CYC);
      end
      ST_WRITE: if (tim_last) begin
        nxt      = ST_WREC;
        tim_load = 1'b1;
        tim_len  = TCW'(REC_CYC);
      end
      ST_WREC: if (tim_last) nxt = ST_DONE;
      ST_READ: if (tim_last) nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_BOOT;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mask_q     <= '0;
      after_rd   <= 1'b0;
      host_ready <= 1'b0;
      host_done  <= 1'b0;
    end else begin
      state      <= nxt;
      mem_cs_n   <= !(nxt == ST_WRITE || nxt == ST_WREC || nxt == ST_READ);
      mem_we_n   <= (nxt != ST_WRITE);
      mem_oe_n   <= (nxt != ST_READ);
      mem_dq_oe  <= (nxt == ST_WRITE);
      host_ready <= (nxt == ST_IDLE);
      host_done  <= (nxt == ST_DONE);
      if (nxt == ST_WRITE || nxt == ST_WREC || nxt == ST_READ) mem_be_n <= ~mask_sel;
      else                                                     mem_be_n <= '1;
      if (accept) begin
        mem_addr   <= host_addr;
        mem_dq_out <= host_wdata;
        mask_q     <= host_mask;
      end
      if (capture)              after_rd <= 1'b1;
      else if (nxt == ST_WRITE) after_rd <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk
  import sram_bridge_pkg::*;
#(
  parameter int AW         = 18,
  parameter int DW         = 16,
  parameter int CLK_NS     = 20,
  parameter int T_PWRUP_NS = 200000
) (
  input logic            clk,
  input logic            rst,
  input logic            host_ready,
  input logic            host_done,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_cs_n,
  input logic            mem_we_n,
  input logic            mem_oe_n,
  input logic [DW-1:0]   mem_dq_out,
  input logic            mem_dq_oe
);
  localparam int PWR = ns_to_cyc(T_PWRUP_NS, CLK_NS);
  localparam int CW  = $clog2(PWR + 2);
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                      since_rst <= '0;
    else if (since_rst < CW'(PWR)) since_rst <= since_rst + CW'(1);
  end

  p_quiet_boot_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CW'(PWR)) |-> (mem_cs_n && !host_ready));

  p_addr_held_r3: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_no_strobe_clash_r3: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  p_data_held_r5: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

  p_drive_window_r6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  p_turn_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_oe_n));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  p_done_deselect_r8: assert property (@(posedge clk) disable iff (rst)
    host_done |-> mem_cs_n);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_cs_n && !host_done));
endmodule

bind sram_bridge sram_bridge_chk #(
  .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_PWRUP_NS(T_PWRUP_NS)
) i_chk (
  .clk(clk), .rst(rst), .host_ready(host_ready), .host_done(host_done),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_bridge.sv
`timescale 1ns/1ps
module test_sram_bridge;
  localparam int CLK = 20;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int RD  = (cyc(45) > cyc(25)) ? cyc(45) : cyc(25);
  localparam int WR  = (cyc(35) > cyc(25)) ? cyc(35) : cyc(25);
  localparam int REC = (cyc(45) > WR) ? cyc(45) - WR : 1;
  localparam int TA  = cyc(15);
  localparam int PWR = cyc(200000);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0, host_wr = 1'b0;
  logic [17:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_mask = '0;
  logic host_ready, host_done, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] host_rdata, mem_dq_out;
  logic [15:0] mem_dq_in = 16'h5A5A;
  logic [17:0] mem_addr;
  logic [1:0]  mem_be_n;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit last_rd = 1'b0;

  always #(CLK/2) clk = ~clk;

  sram_bridge i_sram_bridge (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
    .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // behavioural memory: stores only lanes enabled at the write-ending edge
  logic [15:0] store  [int];
  logic [15:0] shadow [int];
  logic p_we = 1'b1, p_cs = 1'b1;
  logic [1:0]  p_be = 2'b11;
  logic [17:0] p_addr = '0;
  logic [15:0] p_dq = '0;

  function automatic logic [15:0] rd_store(input int a);
    return store.exists(a) ? store[a] : 16'hC3C3;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (!p_we && mem_we_n && !p_cs) begin
      logic [15:0] w;
      w = rd_store(int'(p_addr));
      if (!p_be[0]) w[7:0]  = p_dq[7:0];
      if (!p_be[1]) w[15:8] = p_dq[15:8];
      store[int'(p_addr)] = w;
    end
    p_we = mem_we_n; p_cs = mem_cs_n; p_be = mem_be_n;
    p_addr = mem_addr; p_dq = mem_dq_out;
    mem_dq_in <= (!mem_cs_n && !mem_oe_n && mem_we_n) ? rd_store(int'(mem_addr)) : 16'h5A5A;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare all pins in the current (post-edge) cycle
  task automatic pins(input string tag, input logic ecs, ewe, eoe, edq,
                      input logic [1:0] ebe, input logic edone, erdy,
                      input logic [17:0] ea, input logic [15:0] ed);
    logic [63:0] a, e;
    a = {22'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, mem_be_n, host_done, host_ready,
         (ecs ? 18'd0 : mem_addr), (edq ? mem_dq_out : 16'd0)};
    e = {22'd0, ecs, ewe, eoe, edq, ebe, edone, erdy, (ecs ? 18'd0 : ea), (edq ? ed : 16'd0)};
    chk(tag, a, e);
  endtask

  task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m);
    logic [15:0] exp_rd;
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d; host_mask = m;
    @(negedge clk);
    host_req = 1'b0; host_wdata = ~d; host_addr = ~a;
    if (wr) begin
      if (last_rd)
        for (int i = 0; i < TA; i++) begin
          pins("R7 turnaround", 1, 1, 1, 0, 2'b11, 0, 0, a, d);
          @(negedge clk);
        end
      for (int i = 0; i < WR; i++) begin
        pins("R5 write strobe R10 lanes", 0, 0, 1, 1, ~m, 0, 0, a, d);
        @(negedge clk);
      end
      for (int i = 0; i < REC; i++) begin
        pins("R5 write recovery", 0, 1, 1, 0, ~m, 0, 0, a, d);
        @(negedge clk);
      end
      begin
        logic [15:0] w;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'hC3C3;
        if (m[0]) w[7:0]  = d[7:0];
        if (m[1]) w[15:8] = d[15:8];
        shadow[int'(a)] = w;
      end
      last_rd = 1'b0;
    end else begin
      for (int i = 0; i < RD; i++) begin
        pins("R3 read phase R10 lanes", 0, 1, 0, 0, ~m, 0, 0, a, d);
        @(negedge clk);
      end
      exp_rd = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'hC3C3;
      if (!m[0]) exp_rd[7:0]  = 8'h00;
      if (!m[1]) exp_rd[15:8] = 8'h00;
      chk("R4 read data", {48'd0, host_rdata}, {48'd0, exp_rd});
      last_rd = 1'b1;
    end
    pins("R8 done pulse", 1, 1, 1, 0, 2'b11, 1, 0, a, d);
    @(negedge clk);
    pins("R9 ready after done", 1, 1, 1, 0, 2'b11, 0, 1, a, d);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    pins("R1 reset state", 1, 1, 1, 0, 2'b11, 0, 0, 18'd0, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    n = 1;
    pins("R1 after release", 1, 1, 1, 0, 2'b11, 0, 0, 18'd0, 16'd0);
    while (!host_ready && n < PWR + 10) begin
      if (!mem_cs_n) chk("R2 select during boot", 1, 0);
      @(negedge clk);
      n++;
    end
    chk("R2 power-up hold-off length", 64'(n), 64'(PWR + 1));

    access(1, 18'd5, 16'h1234, 2'b11);
    access(0, 18'd5, 16'h0000, 2'b11);
    access(1, 18'd5, 16'hABCD, 2'b01);
    access(0, 18'd5, 16'h0000, 2'b10);
    access(1, 18'h3FFFF, 16'h5566, 2'b10);
    access(1, 18'd7, 16'hFFFF, 2'b00);
    access(0, 18'd7, 16'h0000, 2'b11);
    access(0, 18'h3FFFF, 16'h0000, 2'b11);
    access(0, 18'd5, 16'h0000, 2'b00);
    chk("R10 zero-mask read is zero", {48'd0, host_rdata}, 64'd0);
    access(0, 18'd5, 16'h0000, 2'b01);
    access(1, 18'd9, 16'h0F0F, 2'b11);
    access(1, 18'd9, 16'hF00F, 2'b10);
    access(0, 18'd9, 16'h0000, 2'b11);
    repeat (3) begin
      @(negedge clk);
      pins("R9 idle stays quiet", 1, 1, 1, 0, 2'b11, 0, 1, 18'd0, 16'd0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule